// File: doc/BRIEF.md
# Integer Load Address and Extend Unit

This unit performs one integer load at a time. Each load arrives as a decoded operation. The unit forms the effective address (EA) from a base operand and either a sign-extended 16-bit displacement or a second register value. If the access is aligned, it issues a word-aligned memory request. When the response returns, it selects the byte or halfword lane and zero- or sign-extends it. It then offers one result beat. That beat carries the destination register write and, for update forms, a writeback of the EA into the base register.

Data moves through three valid/ready channels: operation in, memory request out, and result out. One channel is valid/ready in the other direction: the memory response in. A transfer happens on a rising edge where both valid and ready are high. While a request or a result waits for its ready, its valid and payload stay constant. The unit raises `in_ready` only when no load is in flight. A stalled downstream therefore holds off new operations without losing data. The alignment-error and invalid-form outputs are plain one-cycle pulses.

Top module: `lsu_load_unit`

## Requirements
- R1: A base field of 0 makes the base operand the constant 0, whatever `in_base_val` holds.
- R2: With `in_indexed`=0, EA = base operand + the sign-extended `in_disp`, modulo 2^32.
- R3: With `in_indexed`=1, EA = base operand + `in_index_val`, modulo 2^32.
- R4: For an update load (`in_update`=1) with a valid form, the result beat has `wb_base_we`=1, `wb_base_sel` equal to the base field and `wb_base_data` equal to the EA.
- R5: An update load whose base field is 0 or equals the destination field pulses `form_err` for one cycle, in the cycle after acceptance. It still performs the load, but `wb_base_we` stays 0.
- R6: Size codes are 0 byte, 1 halfword, 2 word, and 3 behaves as word. Response data is a big-endian word. Byte offset k takes bits [31-8k:24-8k]. Halfword offset 0 takes [31:16] and offset 2 takes [15:0]. Without sign extension the lane is placed low in `wb_dst_data` and the upper bits are zero.
- R7: A halfword load with `in_signed`=1 copies bit 15 of the lane through bits 31:16. For byte and word loads, `in_signed` has no effect.
- R8: A halfword at an odd EA, or a word at an EA whose low two bits are nonzero, pulses `align_err` in the cycle after acceptance. Such a load produces no memory request and no result beat, and `in_ready` is high again in that same cycle.
- R9: `req_addr` is the EA with bits 1:0 cleared. `req_size` is the normalised size code (3 becomes 2). Both hold steady with `req_valid` until `req_ready`.
- R10: `in_ready` is high only when no load is in flight. `wb_valid` rises only after a response has been taken, and `wb_*` stays stable until `wb_ready`.
- R11: After reset `in_ready`=1, and `req_valid`, `rsp_ready`, `wb_valid`, `align_err` and `form_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation valid |
| in_ready | output | 1 | Unit idle, operation accepted on this edge |
| in_size | input | 2 | Access size code |
| in_signed | input | 1 | Sign-extend a halfword |
| in_update | input | 1 | Write EA back into base register |
| in_indexed | input | 1 | Use `in_index_val` instead of displacement |
| in_base_sel | input | 5 | Base register field |
| in_dst_sel | input | 5 | Destination register field |
| in_base_val | input | 32 | Contents of the base register |
| in_index_val | input | 32 | Contents of the index register |
| in_disp | input | 16 | Signed displacement |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts request |
| req_addr | output | 32 | Word-aligned request address |
| req_size | output | 2 | Normalised size code |
| rsp_valid | input | 1 | Response data valid |
| rsp_ready | output | 1 | Unit waiting for response |
| rsp_data | input | 32 | Big-endian response word |
| wb_valid | output | 1 | Result beat valid |
| wb_ready | input | 1 | Register file takes result |
| wb_dst_sel | output | 5 | Destination register index |
| wb_dst_data | output | 32 | Extended load data |
| wb_base_we | output | 1 | Base writeback enable |
| wb_base_sel | output | 5 | Base register index |
| wb_base_data | output | 32 | EA for base writeback |
| align_err | output | 1 | One-cycle misalignment pulse |
| form_err | output | 1 | One-cycle invalid update-form pulse |

## Verification
The handshake properties assume that the memory side drives `rsp_valid` only while the unit shows `rsp_ready`, and that `wb_ready` may go high or low at any time. The bench drives each response only after it has seen the matching request accepted. It inserts random stall cycles on `req_ready`, `rsp_valid` and `wb_ready`. The stimulus mixes a sizeable share of misaligned and invalid-form operations. Fields are skewed toward a base field of 0 and toward equal base and destination fields, so that both error paths and the literal-zero base are exercised often.

// File: rtl/lsu_ld_pkg.sv
package lsu_ld_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } ld_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RESP = 2'd2,
    ST_WB   = 2'd3
  } ld_state_e;

  // The reserved code behaves as a full word everywhere.
  function automatic ld_size_e norm_size(input logic [1:0] raw);
    return (raw == 2'd3) ? SZ_WORD : ld_size_e'(raw);
  endfunction

endpackage

// File: rtl/lsu_ld_agen.sv
module lsu_ld_agen
  import lsu_ld_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int RAW   = 5,
  parameter int DISPW = 16
) (
  input  logic [RAW-1:0]  base_sel,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] index_val,
  input  logic [DISPW-1:0] disp,
  input  logic            indexed,
  input  ld_size_e        size,
  output logic [XLEN-1:0] ea,
  output logic            misaligned
);
  localparam int OFFW = $clog2(XLEN/8);

  logic [XLEN-1:0] base_op;
  logic [XLEN-1:0] addend;

  always_comb begin
    base_op = (base_sel == '0) ? '0 : base_val;
    addend  = indexed ? index_val : {{(XLEN-DISPW){disp[DISPW-1]}}, disp};
    ea      = base_op + addend;
    unique case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = ea[0];
      default: misaligned = |ea[OFFW-1:0];
    endcase
  end
endmodule

// File: rtl/lsu_ld_extend.sv
module lsu_ld_extend
  import lsu_ld_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]          word_i,
  input  logic [$clog2(XLEN/8)-1:0] off_i,
  input  ld_size_e                 size_i,
  input  logic                     sgn_i,
  output logic [XLEN-1:0]          data_o
);
  localparam int NBYTE = XLEN / 8;
  localparam int NHALF = XLEN / 16;
  localparam int OFFW  = $clog2(NBYTE);

  logic [7:0]  lane_b [NBYTE];
  logic [15:0] lane_h [NHALF];

  // Big-endian: lane 0 is the most significant slice.
  for (genvar gb = 0; gb < NBYTE; gb++) begin : g_blane
    assign lane_b[gb] = word_i[XLEN-1-8*gb -: 8];
  end
  for (genvar gh = 0; gh < NHALF; gh++) begin : g_hlane
    assign lane_h[gh] = word_i[XLEN-1-16*gh -: 16];
  end

  logic [15:0] half_sel;

  always_comb begin
    half_sel = lane_h[off_i[OFFW-1:1]];
    unique case (size_i)
      SZ_BYTE: data_o = {{(XLEN-8){1'b0}}, lane_b[off_i]};
      SZ_HALF: data_o = {{(XLEN-16){sgn_i & half_sel[15]}}, half_sel};
      default: data_o = word_i;
    endcase
  end
endmodule

// File: rtl/lsu_ld_ctrl.sv
module lsu_ld_ctrl
  import lsu_ld_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic misaligned,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic wb_ready,
  output logic in_ready,
  output logic accept,
  output logic req_valid,
  output logic rsp_ready,
  output logic rsp_take,
  output logic wb_valid
);
  ld_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (in_valid && !misaligned) st_d = ST_REQ;
      ST_REQ:  if (req_ready)               st_d = ST_RESP;
      ST_RESP: if (rsp_valid)               st_d = ST_WB;
      ST_WB:   if (wb_ready)                st_d = ST_IDLE;
      default:                              st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign in_ready  = (st_q == ST_IDLE);
  assign accept    = in_ready & in_valid;
  assign req_valid = (st_q == ST_REQ);
  assign rsp_ready = (st_q == ST_RESP);
  assign rsp_take  = rsp_ready & rsp_valid;
  assign wb_valid  = (st_q == ST_WB);
endmodule

// File: rtl/lsu_load_unit.sv
module lsu_load_unit
  import lsu_ld_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int RAW   = 5,
  parameter int DISPW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_size,
  input  logic             in_signed,
  input  logic             in_update,
  input  logic             in_indexed,
  input  logic [RAW-1:0]   in_base_sel,
  input  logic [RAW-1:0]   in_dst_sel,
  input  logic [XLEN-1:0]  in_base_val,
  input  logic [XLEN-1:0]  in_index_val,
  input  logic [DISPW-1:0] in_disp,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [XLEN-1:0]  req_addr,
  output logic [1:0]       req_size,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [XLEN-1:0]  rsp_data,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic [RAW-1:0]   wb_dst_sel,
  output logic [XLEN-1:0]  wb_dst_data,
  output logic             wb_base_we,
  output logic [RAW-1:0]   wb_base_sel,
  output logic [XLEN-1:0]  wb_base_data,
  output logic             align_err,
  output logic             form_err
);
  localparam int OFFW = $clog2(XLEN/8);

  ld_size_e        size_n;
  logic [XLEN-1:0] ea;
  logic            misaligned;
  logic            accept;
  logic            rsp_take;
  logic            bad_form;
  logic [XLEN-1:0] ext_data;

  ld_size_e        size_q;
  logic            sgn_q;
  logic            upd_ok_q;
  logic [RAW-1:0]  base_sel_q;
  logic [RAW-1:0]  dst_sel_q;
  logic [XLEN-1:0] ea_q;
  logic [XLEN-1:0] data_q;
  logic            align_q;
  logic            form_q;

  assign size_n   = norm_size(in_size);
  assign bad_form = in_update & ((in_base_sel == '0) | (in_base_sel == in_dst_sel));

  lsu_ld_agen #(.XLEN(XLEN), .RAW(RAW), .DISPW(DISPW)) u_agen (
    .base_sel   (in_base_sel),
    .base_val   (in_base_val),
    .index_val  (in_index_val),
    .disp       (in_disp),
    .indexed    (in_indexed),
    .size       (size_n),
    .ea         (ea),
    .misaligned (misaligned)
  );

  lsu_ld_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .misaligned (misaligned),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .wb_ready   (wb_ready),
    .in_ready   (in_ready),
    .accept     (accept),
    .req_valid  (req_valid),
    .rsp_ready  (rsp_ready),
    .rsp_take   (rsp_take),
    .wb_valid   (wb_valid)
  );

  lsu_ld_extend #(.XLEN(XLEN)) u_ext (
    .word_i (rsp_data),
    .off_i  (ea_q[OFFW-1:0]),
    .size_i (size_q),
    .sgn_i  (sgn_q),
    .data_o (ext_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q     <= SZ_BYTE;
      sgn_q      <= 1'b0;
      upd_ok_q   <= 1'b0;
      base_sel_q <= '0;
      dst_sel_q  <= '0;
      ea_q       <= '0;
      data_q     <= '0;
      align_q    <= 1'b0;
      form_q     <= 1'b0;
    end else begin
      align_q <= accept & misaligned;
      form_q  <= accept & bad_form;
      if (accept) begin
        size_q     <= size_n;
        sgn_q      <= in_signed;
        upd_ok_q   <= in_update & ~bad_form;
        base_sel_q <= in_base_sel;
        dst_sel_q  <= in_dst_sel;
        ea_q       <= ea;
      end
      if (rsp_take) data_q <= ext_data;
    end
  end

  assign req_addr     = {ea_q[XLEN-1:OFFW], {OFFW{1'b0}}};
  assign req_size     = size_q;
  assign wb_dst_sel   = dst_sel_q;
  assign wb_dst_data  = data_q;
  assign wb_base_we   = wb_valid & upd_ok_q;
  assign wb_base_sel  = base_sel_q;
  assign wb_base_data = ea_q;
  assign align_err    = align_q;
  assign form_err     = form_q;
endmodule

// File: rtl/lsu_load_unit_chk.sv
module lsu_load_unit_chk #(
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            req_valid,
  input logic            req_ready,
  input logic [XLEN-1:0] req_addr,
  input logic [1:0]      req_size,
  input logic            rsp_ready,
  input logic            wb_valid,
  input logic            wb_ready,
  input logic [RAW-1:0]  wb_dst_sel,
  input logic [XLEN-1:0] wb_dst_data,
  input logic            wb_base_we,
  input logic [RAW-1:0]  wb_base_sel,
  input logic [XLEN-1:0] wb_base_data,
  input logic            align_err,
  input logic            form_err
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_size));

  // R9
  req_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[1:0] == 2'b00 && req_size != 2'd3);

  // R10
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_dst_data) && $stable(wb_dst_sel)
      && $stable(wb_base_we) && $stable(wb_base_data) && $stable(wb_base_sel));

  // R10
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, req_valid, rsp_ready, wb_valid}));

  // R10
  wb_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(rsp_ready));

  // R5
  no_bad_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_base_we |-> wb_valid && wb_base_sel != '0 && wb_base_sel != wb_dst_sel);

  // R8
  align_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> in_ready && !req_valid);

  // R5
  form_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    form_err |=> !form_err);
endmodule

bind lsu_load_unit lsu_load_unit_chk #(.XLEN(XLEN), .RAW(RAW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_ready     (in_ready),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_addr     (req_addr),
  .req_size     (req_size),
  .rsp_ready    (rsp_ready),
  .wb_valid     (wb_valid),
  .wb_ready     (wb_ready),
  .wb_dst_sel   (wb_dst_sel),
  .wb_dst_data  (wb_dst_data),
  .wb_base_we   (wb_base_we),
  .wb_base_sel  (wb_base_sel),
  .wb_base_data (wb_base_data),
  .align_err    (align_err),
  .form_err     (form_err)
);

// File: tb/lsu_load_unit_bench.sv
`timescale 1ns/1ps
module lsu_load_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_size = '0;
  logic        in_signed = 1'b0;
  logic        in_update = 1'b0;
  logic        in_indexed = 1'b0;
  logic [4:0]  in_base_sel = '0;
  logic [4:0]  in_dst_sel = '0;
  logic [31:0] in_base_val = '0;
  logic [31:0] in_index_val = '0;
  logic [15:0] in_disp = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic        rsp_valid = 1'b0;
  logic        rsp_ready;
  logic [31:0] rsp_data = '0;
  logic        wb_valid;
  logic        wb_ready = 1'b0;
  logic [4:0]  wb_dst_sel;
  logic [31:0] wb_dst_data;
  logic        wb_base_we;
  logic [4:0]  wb_base_sel;
  logic [31:0] wb_base_data;
  logic        align_err;
  logic        form_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lsu_load_unit u_lsu_load_unit (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_ea(input logic [4:0] bs, input logic [31:0] bv,
                                       input logic ix, input logic [31:0] iv, input logic [15:0] d);
    logic [31:0] b = (bs == 0) ? 32'd0 : bv;
    return ix ? b + iv : b + {{16{d[15]}}, d};
  endfunction

  function automatic logic [1:0] f_sz(input logic [1:0] s);
    return (s == 2'd3) ? 2'd2 : s;
  endfunction

  function automatic bit f_mis(input logic [1:0] s, input logic [31:0] ea);
    case (f_sz(s))
      2'd0: return 1'b0;
      2'd1: return ea[0];
      default: return ea[1:0] != 2'b00;
    endcase
  endfunction

  function automatic logic [31:0] f_data(input logic [1:0] s, input logic sg,
                                         input logic [1:0] off, input logic [31:0] w);
    logic [7:0] b;
    logic [15:0] h;
    case (f_sz(s))
      2'd0: begin b = w[31-8*off -: 8]; return {24'd0, b}; end
      2'd1: begin h = off[1] ? w[15:0] : w[31:16]; return {{16{sg & h[15]}}, h}; end
      default: return w;
    endcase
  endfunction

  task automatic run_op(input logic [1:0] s, input logic sg, input logic up, input logic ix,
                        input logic [4:0] bs, input logic [4:0] ds, input logic [31:0] bv,
                        input logic [31:0] iv, input logic [15:0] d, input logic [31:0] mem,
                        input string tag);
    logic [31:0] ea = f_ea(bs, bv, ix, iv, d);
    bit mis = f_mis(s, ea);
    bit bad = up && (bs == 0 || bs == ds);
    logic [31:0] ed = f_data(s, sg, ea[1:0], mem);
    logic [31:0] ra;
    int w;
    w = 0;
    while (!in_ready && w < 50) begin @(negedge clk); w++; end
    in_valid = 1; in_size = s; in_signed = sg; in_update = up; in_indexed = ix;
    in_base_sel = bs; in_dst_sel = ds; in_base_val = bv; in_index_val = iv; in_disp = d;
    @(negedge clk);
    in_valid = 0;
    chk(align_err == mis, {tag, " R8 align_err"}, align_err, mis);
    chk(form_err == bad, {tag, " R5 form_err"}, form_err, bad);
    if (mis) begin
      chk(!req_valid && in_ready, {tag, " R8 no request"}, {req_valid, in_ready}, 2'b01);
      @(negedge clk);
      chk(!align_err && !req_valid && !wb_valid, {tag, " R8 pulse/no beat"},
          {align_err, req_valid, wb_valid}, 0);
      return;
    end
    chk(req_valid && !in_ready, {tag, " R10 busy"}, {req_valid, in_ready}, 2'b10);
    chk(req_addr == {ea[31:2], 2'b00}, {tag, " R2 R3 R9 req_addr"}, req_addr, {ea[31:2], 2'b00});
    chk(req_size == f_sz(s), {tag, " R9 req_size"}, req_size, f_sz(s));
    ra = req_addr;
    for (int k = 0; k < $urandom_range(0, 3); k++) begin
      @(negedge clk);
      chk(req_valid && req_addr == ra, {tag, " R9 hold"}, req_addr, ra);
    end
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    for (int k = 0; k < $urandom_range(0, 3); k++) begin
      @(negedge clk);
      chk(!wb_valid && rsp_ready, {tag, " R10 wait rsp"}, wb_valid, 0);
    end
    rsp_valid = 1; rsp_data = mem;
    @(negedge clk);
    rsp_valid = 0; rsp_data = $urandom;
    for (int k = 0; k <= $urandom_range(0, 3); k++) begin
      chk(wb_valid, {tag, " R10 wb_valid"}, wb_valid, 1);
      chk(wb_dst_data == ed, {tag, " R6 R7 data"}, wb_dst_data, ed);
      chk(wb_dst_sel == ds, {tag, " R10 dst_sel"}, wb_dst_sel, ds);
      chk(wb_base_we == (up && !bad), {tag, " R4 R5 base_we"}, wb_base_we, up && !bad);
      if (up && !bad) begin
        chk(wb_base_sel == bs, {tag, " R4 base_sel"}, wb_base_sel, bs);
        chk(wb_base_data == ea, {tag, " R4 base_data"}, wb_base_data, ea);
      end
      wb_ready = (k > 0) || ($urandom_range(0, 1) == 1);
      @(negedge clk);
      if (wb_ready) break;
    end
    if (!wb_ready) begin wb_ready = 1; @(negedge clk); end
    wb_ready = 0;
    chk(!wb_valid && in_ready, {tag, " R10 back idle"}, {wb_valid, in_ready}, 2'b01);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R10 actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(in_ready && !req_valid && !rsp_ready && !wb_valid && !align_err && !form_err,
        "R11 reset", {in_ready, req_valid, rsp_ready, wb_valid, align_err, form_err}, 6'b100000);
    rst_n = 1;
    @(negedge clk);

    // R1 base field zero ignores base value
    run_op(2, 0, 0, 0, 0, 3, 32'hFFFF_0000, 0, 16'h0100, 32'hCAFE_BABE, "R1 zero base");
    // R2 negative displacement wraps
    run_op(2, 0, 1, 0, 7, 3, 32'h0000_0004, 0, 16'hFFF8, 32'h1234_5678, "R2 wrap R4");
    // R3 indexed
    run_op(1, 1, 0, 1, 9, 4, 32'h1000_0000, 32'h0000_0022, 0, 32'h0102_F3F4, "R3 indexed R7");
    // R6 each byte lane
    for (int k = 0; k < 4; k++)
      run_op(0, 0, 0, 0, 5, 6, 32'h2000_0000 + k, 0, 0, 32'h8192_A3B4, "R6 byte lane");
    // R7 signed flag ignored on byte and word
    run_op(0, 1, 0, 0, 5, 6, 32'h2000_0000, 0, 0, 32'hF000_0000, "R7 byte signed");
    run_op(2, 1, 0, 0, 5, 6, 32'h2000_0000, 0, 0, 32'hF000_8000, "R7 word signed");
    run_op(1, 0, 0, 0, 5, 6, 32'h2000_0000, 0, 0, 32'h8001_0000, "R6 half zero");
    run_op(1, 1, 0, 0, 5, 6, 32'h2000_0000, 0, 0, 32'h8001_0000, "R7 half signed");
    // R5 invalid update forms
    run_op(2, 0, 1, 0, 8, 8, 32'h3000_0000, 0, 4, 32'h5555_AAAA, "R5 base eq dst");
    run_op(2, 0, 1, 1, 0, 8, 32'h3000_0000, 32'h40, 0, 32'h5555_AAAA, "R5 base zero");
    // R8 misaligned half and word, size code 3
    run_op(1, 0, 0, 0, 5, 6, 32'h2000_0001, 0, 0, 0, "R8 half odd");
    run_op(2, 0, 0, 0, 5, 6, 32'h2000_0002, 0, 0, 0, "R8 word off2");
    run_op(3, 0, 0, 0, 5, 6, 32'h2000_0001, 0, 0, 0, "R8 R9 size3 mis");
    run_op(3, 0, 0, 0, 5, 6, 32'h2000_0004, 0, 0, 32'h0BAD_F00D, "R9 size3");

    for (int n = 0; n < 400; n++) begin
      logic [1:0] s = 2'($urandom_range(0, 3));
      logic [4:0] bs = ($urandom_range(0, 4) == 0) ? 5'd0 : 5'($urandom);
      logic [4:0] ds = ($urandom_range(0, 4) == 0) ? bs : 5'($urandom);
      logic ix = 1'($urandom);
      logic [31:0] bv = $urandom;
      logic [31:0] iv = $urandom;
      logic [15:0] d = 16'($urandom);
      logic [31:0] ea = f_ea(bs, bv, ix, iv, d);
      if ($urandom_range(0, 3) != 0) begin
        logic [31:0] fix = (f_sz(s) == 2'd1) ? {31'd0, ea[0]} :
                           (f_sz(s) == 2'd0) ? 32'd0 : {30'd0, ea[1:0]};
        if (ix) iv = iv - fix;
        else d = d - 16'(fix);
      end
      run_op(s, 1'($urandom), 1'($urandom), ix, bs, ds, bv, iv, d, $urandom, "rand");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule